// File: doc/BRIEF.md
# Interrupt Source Gateway with Event Queue

This block conditions one raw interrupt line before it reaches an interrupt prioritisation core. It turns the line into a single pending request for the core. Once software claims that request, the gateway holds back any further request from the same line until software signals that servicing is done. One instance serves one source.

Each source can run in one of two trigger modes. In level mode the request follows the sampled line. A line that stays high while its request is being serviced produces no extra work. In rising-edge mode every rising edge is recorded in a saturating event counter, so bursts of edges that arrive during servicing are replayed one at a time after each completion. Edges beyond the counter limit are dropped without notice.

The priority comparison, the enable matrix and the register bus all lie outside this block. The claim and completion strobes come from the surrounding core once it has decoded the software accesses.

Top module: `irq_gateway`

## Requirements
- R1: `edge_mode_i` = 1 selects rising-edge triggering and `edge_mode_i` = 0 selects level triggering. A rising edge is the line sampled high on a clock edge after being sampled low on the previous clock edge, so a line held high yields one event.
- R2: In level mode, `pending_o` is high exactly when the line was high at the most recent clock edge and the gateway is not blocked. No events are counted in level mode.
- R3: In edge mode, every rising edge that arrives while a request is outstanding is recorded, and it later produces one request of its own.
- R4: The event count saturates at `EVT_LIMIT`, and edges beyond it are dropped. With `EVT_LIMIT` = 0, one event is held.
- R5: An accepted claim in edge mode lowers the event count by exactly one.
- R6: A rising edge in the same cycle as an accepted claim leaves the event count unchanged.
- R7: From the clock edge that accepts a claim until a completion is taken, `pending_o` stays low.
- R8: A completion that arrives while blocked re-enables forwarding from the next clock edge. A completion that arrives while not blocked has no effect.
- R9: A claim is accepted only when `pending_o` is high. A claim made while `pending_o` is low changes nothing.
- R10: A synchronous active-high `rst` clears the event count, the blocked state and the line history, so `pending_o` is low right after reset.
- R11: Every result appears on `pending_o` after the first rising clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 1 | Raw interrupt line |
| edge_mode_i | input | 1 | 1 = rising-edge mode, 0 = level mode |
| claim_i | input | 1 | Claim strobe from the core |
| complete_i | input | 1 | Completion strobe from the core |
| pending_o | output | 1 | Request forwarded to the prioritisation core |

## Verification
Every state change in the gateway (line history, event count, blocked flag) is registered at a single clock edge. A stimulus driven before an edge is therefore visible on `pending_o` after that edge, with a latency of one cycle. The bench drives inputs on the falling edge. It advances its own reference model at the following rising edge and compares `pending_o` on the next falling edge, so each comparison falls exactly one cycle after its stimulus. The directed sequences cover saturation, a claim that coincides with an edge, strobes that arrive at the wrong time, and reset with events queued. Long seeded random runs then mix all of these.

// File: rtl/gw_pkg.sv
package gw_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_RISE  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic rise;
        logic level;
    } line_evt_t;

    typedef struct packed {
        logic accept;
        logic done;
    } svc_req_t;

    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/gw_line_sampler.sv
module gw_line_sampler
    import gw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      src,
    output line_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src;
    end

    always_comb begin
        evt.rise  = src & ~prev_q;
        evt.level = prev_q;
    end
endmodule

// File: rtl/gw_event_counter.sv
module gw_event_counter
    import gw_pkg::*;
#(
    parameter int unsigned EVT_LIMIT = 8,
    parameter int unsigned CW        = cnt_width(EVT_LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  trig_mode_e    mode,
    input  logic          rise,
    input  logic          take,
    output logic [CW-1:0] count
);
    generate
        if (EVT_LIMIT == 0) begin : g_flag
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst || mode == TRIG_LEVEL) held_q <= 1'b0;
                else if (rise && !take)        held_q <= 1'b1;
                else if (take && !rise)        held_q <= 1'b0;
            end
            assign count = CW'(held_q);
        end else begin : g_counter
            localparam logic [CW-1:0] CNT_MAX = CW'(EVT_LIMIT);
            logic [CW-1:0] cnt_q;
            logic [CW-1:0] cnt_d;

            always_comb begin
                cnt_d = cnt_q;
                if (mode == TRIG_LEVEL) begin
                    cnt_d = '0;
                end else if (rise && !take) begin
                    if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
                end else if (take && !rise) begin
                    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end
            assign count = cnt_q;
        end
    endgenerate
endmodule

// File: rtl/gw_service_lock.sv
module gw_service_lock
    import gw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  svc_req_t req,
    output logic     blocked
);
    logic blk_q;

    always_ff @(posedge clk) begin
        if (rst)            blk_q <= 1'b0;
        else if (req.accept) blk_q <= 1'b1;
        else if (req.done)   blk_q <= 1'b0;
    end

    assign blocked = blk_q;
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import gw_pkg::*;
#(
    parameter int unsigned EVT_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);
    localparam int unsigned CW = cnt_width(EVT_LIMIT);

    trig_mode_e    mode;
    line_evt_t     line_evt;
    svc_req_t      svc_req;
    logic [CW-1:0] evt_count;
    logic          svc_blocked;
    logic          line_rise;
    logic          claim_ok;
    logic          raw_req;

    assign mode      = trig_mode_e'(edge_mode_i);
    assign line_rise = line_evt.rise;

    gw_line_sampler u_sampler (
        .clk (clk),
        .rst (rst),
        .src (src_i),
        .evt (line_evt)
    );

    gw_event_counter #(
        .EVT_LIMIT (EVT_LIMIT),
        .CW        (CW)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .rise  (line_evt.rise),
        .take  (claim_ok),
        .count (evt_count)
    );

    gw_service_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .req     (svc_req),
        .blocked (svc_blocked)
    );

    always_comb begin
        raw_req        = (mode == TRIG_RISE) ? (evt_count != '0) : line_evt.level;
        pending_o      = raw_req & ~svc_blocked;
        claim_ok       = claim_i & pending_o;
        svc_req.accept = claim_ok;
        svc_req.done   = complete_i;
    end
endmodule

// File: rtl/irq_gateway_chk.sv
module irq_gateway_chk #(
    parameter int unsigned EVT_LIMIT = 8,
    parameter int unsigned CW        = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          edge_mode_i,
    input logic          claim_i,
    input logic          complete_i,
    input logic          pending_o,
    input logic          line_rise,
    input logic [CW-1:0] evt_count,
    input logic          svc_blocked
);
    localparam logic [CW-1:0] CMAX = CW'((EVT_LIMIT == 0) ? 1 : EVT_LIMIT);

    a_r7_block_after_claim: assert property (@(posedge clk) disable iff (rst)
        (claim_i && pending_o) |=> !pending_o);

    a_r7_blocked_silent: assert property (@(posedge clk) disable iff (rst)
        svc_blocked |-> !pending_o);

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (svc_blocked && complete_i && !claim_i) |=> !svc_blocked);

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && line_rise && !(claim_i && pending_o) && evt_count == CMAX)
        |=> (evt_count == CMAX));

    a_r5_claim_decrement: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && claim_i && pending_o && !line_rise)
        |=> (evt_count == $past(evt_count) - 1'b1));

    a_r6_claim_with_edge: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && claim_i && pending_o && line_rise) |=> $stable(evt_count));

    a_r9_idle_claim: assert property (@(posedge clk) disable iff (rst)
        (claim_i && !pending_o && !complete_i) |=> (svc_blocked == $past(svc_blocked)));
endmodule

bind irq_gateway irq_gateway_chk #(
    .EVT_LIMIT (EVT_LIMIT),
    .CW        (CW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .edge_mode_i (edge_mode_i),
    .claim_i     (claim_i),
    .complete_i  (complete_i),
    .pending_o   (pending_o),
    .line_rise   (line_rise),
    .evt_count   (evt_count),
    .svc_blocked (svc_blocked)
);

// File: tb/tb_irq_gateway.sv
module tb_irq_gateway;
    localparam int unsigned LIM = 3;

    logic clk = 1'b0;
    logic rst, src, mode, claim, done;
    logic pend;

    int checks = 0;
    int errors = 0;

    int  m_cnt;
    logic m_prev, m_blk;

    always #5 clk = ~clk;

    irq_gateway #(.EVT_LIMIT(LIM)) dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .edge_mode_i (mode),
        .claim_i     (claim),
        .complete_i  (done),
        .pending_o   (pend)
    );

    function automatic logic exp_pend(input logic md);
        return !m_blk && (md ? (m_cnt != 0) : m_prev);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pending_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input string req, input logic s, input logic md,
                        input logic c, input logic d);
        logic rise, acc;
        src = s; mode = md; claim = c; done = d;
        rise = s && !m_prev;
        acc  = c && exp_pend(md);
        @(posedge clk);
        if (acc)       m_blk = 1'b1;
        else if (d)    m_blk = 1'b0;
        if (!md)                m_cnt = 0;
        else if (rise && !acc)  m_cnt = (m_cnt < LIM) ? m_cnt + 1 : m_cnt;
        else if (acc && !rise)  m_cnt = m_cnt - 1;
        m_prev = s;
        @(negedge clk);
        check(req, pend, exp_pend(md));
    endtask

    task automatic do_reset();
        rst = 1'b1; claim = 1'b0; done = 1'b0;
        @(posedge clk);
        m_cnt = 0; m_prev = 1'b0; m_blk = 1'b0;
        @(negedge clk);
        check("R10", pend, 1'b0);
        rst = 1'b0;
    endtask

    task automatic serve(input string req, input logic md);
        step(req, 1'b0, md, 1'b1, 1'b0);
        step(req, 1'b0, md, 1'b0, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        src = 1'b1; mode = 1'b1; claim = 1'b0; done = 1'b0; rst = 1'b1;
        @(negedge clk);
        do_reset();

        // R1 R11: line held high through reset gives one edge event
        step("R1", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R1", 1'b1, 1'b1, 1'b0, 1'b0);
        serve("R5", 1'b1);
        step("R1", 1'b1, 1'b1, 1'b0, 1'b0);

        // R2: level mode, serviced line held high requests again; low line is ignored
        step("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        step("R11", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R7", 1'b1, 1'b0, 1'b1, 1'b0);
        step("R7", 1'b1, 1'b0, 1'b0, 1'b0);
        step("R8", 1'b1, 1'b0, 1'b0, 1'b1);
        step("R7", 1'b0, 1'b0, 1'b1, 1'b0);
        step("R2", 1'b0, 1'b0, 1'b0, 1'b1);

        // R3 R4: five edges while blocked, only LIM replayed
        step("R3", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R7", 1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step("R3", 1'b1, 1'b1, 1'b0, 1'b0);
            step("R3", 1'b0, 1'b1, 1'b0, 1'b0);
        end
        step("R8", 1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < LIM + 1; i++) serve("R4", 1'b1);

        // R6: edge coincides with claim
        step("R6", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R6", 1'b0, 1'b1, 1'b0, 1'b0);
        step("R6", 1'b1, 1'b1, 1'b1, 1'b0);
        step("R6", 1'b0, 1'b1, 1'b0, 1'b1);
        serve("R6", 1'b1);
        serve("R6", 1'b1);

        // R9 R8: strobes at the wrong time change nothing
        step("R9", 1'b0, 1'b1, 1'b1, 1'b0);
        step("R8", 1'b0, 1'b1, 1'b0, 1'b1);
        step("R9", 1'b1, 1'b1, 1'b0, 1'b0);

        // R10: reset with events queued
        step("R10", 1'b0, 1'b1, 1'b0, 1'b0);
        step("R10", 1'b1, 1'b1, 1'b0, 1'b0);
        do_reset();
        step("R10", 1'b0, 1'b1, 1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic md;
            md = ($urandom % 64 == 0) ? ~mode : mode;
            step("R3", 1'($urandom % 2), md, 1'($urandom % 3 == 0), 1'($urandom % 4 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule